// File: doc/BRIEF.md
# 64-bit Integer Execute Unit with Word Operations

This block is the integer execute stage of a 64-bit load/store RISC core. Each cycle it can accept one operation. The operation carries two 64-bit register operands, a 16-bit immediate and a 4-bit operation code. The block works out the 64-bit result and an integer-overflow trap flag, and registers both once.

The arithmetic paths include full-width add and subtract, which trap on signed overflow. They also include 32-bit word forms, whose result is truncated and then sign-extended to 64 bits. The immediate add and subtract forms each have their own extension rule. The logical operations have register and immediate forms. The block never suppresses a result: when an overflow occurs, it presents the wrapped value and raises the trap output, so that a later stage can cancel the register write.

Top module: `int_exec_alu`

## Requirements
- R1: While reset is asserted and in the cycle after it, `out_valid`, `ovf_trap` and `result` are all zero.
- R2: An operation accepted with `in_valid` high at a clock edge shows its `result` and `ovf_trap` with `out_valid` high after that same edge. The latency is one cycle.
- R3: Operation code 0 computes `src_a + src_b` and code 1 computes `src_a - src_b`, both modulo 2^64. Each raises `ovf_trap` on signed 64-bit overflow.
- R4: Operation codes 2 (word add) and 3 (word subtract) take bits 31:0 of the 64-bit sum or difference and sign-extend them to 64 bits. They never raise `ovf_trap`.
- R5: Operation codes 4 (add immediate) and 6 (subtract immediate) sign-extend the 16-bit `imm` to 64 bits and use it as the second operand. Each raises `ovf_trap` on signed 64-bit overflow.
- R6: Operation codes 5 (add unsigned immediate) and 7 (subtract unsigned immediate) zero-extend `imm`. They never raise `ovf_trap`.
- R7: Operation codes 8, 9, 10 and 11 give AND, OR, XOR and NOR of `src_a` and `src_b`. They never raise `ovf_trap`.
- R8: Operation codes 12, 13 and 14 give AND, OR and XOR of `src_a` with the zero-extended `imm`. They never raise `ovf_trap`.
- R9: When `ovf_trap` is raised, `result` still carries the wrapped two's-complement sum or difference.
- R10: Operation code 15 is reserved. It gives a zero `result` and no trap.
- R11: A cycle with `in_valid` low drives `out_valid` and `ovf_trap` low on the next cycle and leaves `result` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 4 | Operation code (see R3 to R10) |
| src_a | input | 64 | First register operand |
| src_b | input | 64 | Second register operand |
| imm | input | 16 | Immediate field |
| out_valid | output | 1 | Registered result is valid |
| result | output | 64 | Registered result |
| ovf_trap | output | 1 | Integer-overflow trap for the registered result |

## Verification
The bench builds the block with its default widths: 64-bit data, 32-bit words and a 16-bit immediate. At these widths, random operands reach signed overflow at bit 63. They also reach sign flips at bit 31 for the word forms, and immediates whose top bit separates sign extension from zero extension. Directed cases add the extreme values: the largest positive value plus one, zero minus the most negative value, and the word boundary 0x7FFFFFFF plus one.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_ADDW  = 4'd2,
    OP_SUBW  = 4'd3,
    OP_ADDI  = 4'd4,
    OP_ADDIU = 4'd5,
    OP_SUBI  = 4'd6,
    OP_SUBIU = 4'd7,
    OP_AND   = 4'd8,
    OP_OR    = 4'd9,
    OP_XOR   = 4'd10,
    OP_NOR   = 4'd11,
    OP_ANDI  = 4'd12,
    OP_ORI   = 4'd13,
    OP_XORI  = 4'd14,
    OP_RSVD  = 4'd15
  } alu_op_e;

  function automatic logic op_is_logic(input logic [3:0] code);
    return (code >= 4'd8) && (code <= 4'd14);
  endfunction

  function automatic logic op_is_word(input logic [3:0] code);
    return (code == OP_ADDW) || (code == OP_SUBW);
  endfunction

  function automatic logic op_may_trap(input logic [3:0] code);
    return (code == OP_ADD) || (code == OP_SUB) ||
           (code == OP_ADDI) || (code == OP_SUBI);
  endfunction
endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
  import alu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 16
) (
  input  logic [3:0]      op,
  input  logic [XLEN-1:0] src_b,
  input  logic [IMMW-1:0] imm,
  output logic [XLEN-1:0] opnd_b,
  output logic            do_sub,
  output logic            trap_en
);
  localparam int PADW = XLEN - IMMW;

  logic [XLEN-1:0] imm_sx;
  logic [XLEN-1:0] imm_zx;

  assign imm_sx = {{PADW{imm[IMMW-1]}}, imm};
  assign imm_zx = {{PADW{1'b0}}, imm};

  always_comb begin
    opnd_b  = src_b;
    do_sub  = 1'b0;
    trap_en = op_may_trap(op);
    case (alu_op_e'(op))
      OP_SUB, OP_SUBW:        do_sub = 1'b1;
      OP_ADDI:                opnd_b = imm_sx;
      OP_SUBI:  begin opnd_b = imm_sx; do_sub = 1'b1; end
      OP_ADDIU:               opnd_b = imm_zx;
      OP_SUBIU: begin opnd_b = imm_zx; do_sub = 1'b1; end
      OP_ANDI, OP_ORI, OP_XORI: opnd_b = imm_zx;
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            sub,
  output logic [XLEN-1:0] sum,
  output logic            ovf
);
  logic [XLEN-1:0] b_eff;

  assign b_eff = sub ? ~b : b;
  assign sum   = a + b_eff + {{(XLEN-1){1'b0}}, sub};
  // Signed overflow: addends share a sign that the sum does not.
  assign ovf   = (a[XLEN-1] == b_eff[XLEN-1]) && (sum[XLEN-1] != a[XLEN-1]);
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [3:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res
);
  always_comb begin
    case (alu_op_e'(op))
      OP_AND, OP_ANDI: res = a & b;
      OP_OR,  OP_ORI:  res = a | b;
      OP_XOR, OP_XORI: res = a ^ b;
      OP_NOR:          res = ~(a | b);
      default:         res = '0;
    endcase
  end
endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
  import alu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32,
  parameter int IMMW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [3:0]      op,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [IMMW-1:0] imm,
  output logic            out_valid,
  output logic [XLEN-1:0] result,
  output logic            ovf_trap
);
  localparam int HIW = XLEN - WLEN;

  logic [XLEN-1:0] opnd_b;
  logic            do_sub;
  logic            trap_en;
  logic [XLEN-1:0] sum;
  logic            add_ovf;
  logic [XLEN-1:0] logic_res;
  logic [XLEN-1:0] word_res;
  logic [XLEN-1:0] next_res;

  alu_operand_sel #(.XLEN(XLEN), .IMMW(IMMW)) u_opsel (
    .op(op), .src_b(src_b), .imm(imm),
    .opnd_b(opnd_b), .do_sub(do_sub), .trap_en(trap_en)
  );

  alu_adder #(.XLEN(XLEN)) u_add (
    .a(src_a), .b(opnd_b), .sub(do_sub), .sum(sum), .ovf(add_ovf)
  );

  alu_logic_unit #(.XLEN(XLEN)) u_logic (
    .op(op), .a(src_a), .b(opnd_b), .res(logic_res)
  );

  generate
    if (WLEN < XLEN) begin : g_word_sx
      assign word_res = {{HIW{sum[WLEN-1]}}, sum[WLEN-1:0]};
    end else begin : g_word_full
      assign word_res = sum;
    end
  endgenerate

  always_comb begin
    if (op == OP_RSVD)        next_res = '0;
    else if (op_is_logic(op)) next_res = logic_res;
    else if (op_is_word(op))  next_res = word_res;
    else                      next_res = sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf_trap  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      ovf_trap  <= in_valid & trap_en & add_ovf;
      if (in_valid) result <= next_res;
    end
  end

  // R1: outputs cleared by reset
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && !ovf_trap && result == '0));

  // R2: valid follows the accepting cycle by one
  a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R4: word forms come out sign-extended and never trap
  a_r4_word_sext: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_is_word(op)) |=>
      (!ovf_trap && (result[XLEN-1:WLEN-1] == '0 || result[XLEN-1:WLEN-1] == '1)));

  // R6, R7, R8: non-trapping forms keep the trap low
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op_may_trap(op)) |=> !ovf_trap);

  // R10: reserved code gives zero
  a_r10_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_RSVD) |=> (result == '0 && !ovf_trap));

  // R11: idle cycle holds the result and drops valid and trap
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !$past(rst)) |=> (!out_valid && !ovf_trap && $stable(result)));
endmodule

// File: tb/int_exec_alu_bench.sv
module int_exec_alu_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [3:0]  op;
  logic [63:0] src_a, src_b;
  logic [15:0] imm;
  logic        out_valid;
  logic [63:0] result;
  logic        ovf_trap;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  logic [63:0] last_res = '0;

  always #2.5 clk = ~clk;

  int_exec_alu u_int_exec_alu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .imm(imm),
    .out_valid(out_valid), .result(result), .ovf_trap(ovf_trap)
  );

  function automatic logic [64:0] model(input logic [3:0] c, input logic [63:0] a,
                                        input logic [63:0] b, input logic [15:0] i);
    logic [63:0] sx, zx, r, rhs;
    logic sub, chk, t;
    sx = {{48{i[15]}}, i};
    zx = {48'd0, i};
    sub = 0; chk = 0; rhs = b; r = '0;
    case (c)
      4'd0: begin rhs = b;  chk = 1; end
      4'd1: begin rhs = b;  chk = 1; sub = 1; end
      4'd4: begin rhs = sx; chk = 1; end
      4'd6: begin rhs = sx; chk = 1; sub = 1; end
      4'd5: rhs = zx;
      4'd7: begin rhs = zx; sub = 1; end
      4'd3: sub = 1;
      default: ;
    endcase
    t = 0;
    if (c <= 4'd7) begin
      r = sub ? a - rhs : a + rhs;
      if (chk) begin
        if (sub) t = (a[63] != rhs[63]) && (r[63] != a[63]);
        else     t = (a[63] == rhs[63]) && (r[63] != a[63]);
      end
      if (c == 4'd2 || c == 4'd3) r = {{32{r[31]}}, r[31:0]};
    end else begin
      case (c)
        4'd8:  r = a & b;
        4'd9:  r = a | b;
        4'd10: r = a ^ b;
        4'd11: r = ~(a | b);
        4'd12: r = a & zx;
        4'd13: r = a | zx;
        4'd14: r = a ^ zx;
        default: r = '0;
      endcase
    end
    return {t, r};
  endfunction

  task automatic apply(input logic v, input logic [3:0] c, input logic [63:0] a,
                       input logic [63:0] b, input logic [15:0] i, input string req);
    logic [64:0] e;
    logic [63:0] er;
    logic et;
    @(negedge clk);
    in_valid = v; op = c; src_a = a; src_b = b; imm = i;
    e  = model(c, a, b, i);
    er = v ? e[63:0] : last_res;
    et = v ? e[64] : 1'b0;
    @(posedge clk); #1;
    n_checks++;
    if (out_valid !== v || result !== er || ovf_trap !== et) begin
      n_fail++;
      $display("FAIL %s op=%0d: got v=%0b r=%h t=%0b, expected v=%0b r=%h t=%0b",
               req, c, out_valid, result, ovf_trap, v, er, et);
    end
    last_res = er;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    rst = 1; in_valid = 0; op = 0; src_a = 0; src_b = 0; imm = 0;
    repeat (3) @(posedge clk);
    #1;
    n_checks++;
    if (out_valid !== 0 || result !== 0 || ovf_trap !== 0) begin
      n_fail++;
      $display("FAIL R1: got v=%0b r=%h t=%0b, expected 0 0 0", out_valid, result, ovf_trap);
    end
    @(negedge clk); rst = 0;

    // R3 / R9: overflow with wrapped result
    apply(1, 4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 16'd0, "R3 R9 add ovf");
    apply(1, 4'd1, 64'd0, 64'h8000_0000_0000_0000, 16'd0, "R3 R9 sub ovf");
    apply(1, 4'd1, 64'd5, 64'd7, 16'd0, "R3 sub no ovf");
    // R4: word boundaries
    apply(1, 4'd2, 64'h0000_0000_7FFF_FFFF, 64'd1, 16'd0, "R4 addw");
    apply(1, 4'd3, 64'h7FFF_FFFF_0000_0000, 64'd1, 16'd0, "R4 subw");
    // R5 / R6: extension rules
    apply(1, 4'd4, 64'd10, 64'd0, 16'hFFFF, "R5 addi sext");
    apply(1, 4'd6, 64'h8000_0000_0000_0000, 64'd0, 16'h0001, "R5 subi ovf");
    apply(1, 4'd5, 64'd10, 64'd0, 16'hFFFF, "R6 addiu zext");
    apply(1, 4'd7, 64'd0, 64'd0, 16'h8000, "R6 subiu zext");
    apply(1, 4'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 16'h0001, "R6 carry no trap");
    // R7 / R8 / R10
    apply(1, 4'd11, 64'hF0F0_0000_0000_1234, 64'h0F00_0000_0000_0001, 16'd0, "R7 nor");
    apply(1, 4'd14, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 16'h8001, "R8 xori zext");
    apply(1, 4'd15, 64'h1234, 64'h5678, 16'h9ABC, "R10 reserved");
    // R11: idle cycles hold result
    apply(1, 4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd2, 16'd0, "R2 before idle");
    apply(0, 4'd9, 64'hAAAA, 64'h5555, 16'h1, "R11 idle");
    apply(0, 4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd9, 16'h1, "R11 idle ovf");

    for (int k = 0; k < 3000; k++) begin
      logic [63:0] ra, rb;
      logic [3:0] rc;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      rc = 4'($urandom % 16);
      if ($urandom % 8 == 0) ra[62:0] = ($urandom % 2) ? '1 : '0;
      apply(($urandom % 6) != 0, rc, ra, rb, 16'($urandom), "R2 R3-R8 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule